// File: doc/BRIEF.md
# Four-beat burst address sequencer

This block sits in front of a synchronous pipelined memory array and turns three control strobes, sampled on every rising clock edge, into an array address and a set of cycle qualifiers. A load strobe captures a new external address and opens a burst. A read/write strobe picks the direction of that burst and, on cycles without a load, tells a continue step apart from an idle cycle. A data-rate strobe picks single or double data rate for the burst.

Continue cycles step the two low address bits through a four-beat window. The order is either plain counting or an XOR of the start value with the beat number, selected by an order input sampled at the load. The counter wraps after the fourth beat. The upper address bits come from the loaded address and do not change. A data-pin output enable follows a read burst one clock late, which matches a one-stage output register. It therefore falls one cycle after an idle cycle ends the burst.

The array, the data path and the pad drivers are outside this block. It produces only the address sequence and the control timing.

Top module: `burst_seq_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears `arr_addr`, `is_read`, `ddr_mode` and `dq_oe` to zero at that edge. No burst is open afterwards.
- R2: With `load_n` low at an edge, `arr_addr` equals `ext_addr` after that edge. `is_read` becomes 1 if `rw_sel` was high and 0 if it was low.
- R3: At a load edge, `rate_sel` low sets `ddr_mode` to 1 and `rate_sel` high sets it to 0. On every other edge `rate_sel` is ignored, and `ddr_mode` and `is_read` keep their values.
- R4: With linear order (`linear_order` high at the load), beat k of the burst has low two bits equal to (start + k) mod 4. Example: start 01 gives 01,10,11,00.
- R5: With interleaved order (`linear_order` low at the load), beat k has low two bits equal to start XOR k. Example: start 10 gives 10,11,00,01.
- R6: `arr_addr[ADDR_W-1:2]` stays at the loaded value through every continue. A fourth and later continue wraps the beat count, so the fifth beat returns to the start address.
- R7: `load_n` high with `rw_sel` low is an idle cycle that ends the burst. `arr_addr` holds its value. `dq_oe` is low from the second edge after the idle edge.
- R8: `dq_oe` is high after an edge exactly when the previous edge left a read burst open. It rises one edge after a read load and is never high for a write burst.
- R9: A continue (`load_n` high, `rw_sel` high) with no burst open is ignored. `arr_addr`, `is_read` and `ddr_mode` are unchanged and `dq_oe` stays low.
- R10: Changing `linear_order` during a burst has no effect. The order captured at the load applies until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Low: load `ext_addr` and start a burst |
| rw_sel | input | 1 | Load: 1 read, 0 write. Otherwise: 1 continue, 0 idle |
| rate_sel | input | 1 | At load: 1 single data rate, 0 double data rate |
| linear_order | input | 1 | At load: 1 linear beat order, 0 interleaved |
| ext_addr | input | ADDR_W | External start address |
| arr_addr | output | ADDR_W | Current array address |
| is_read | output | 1 | Direction of the current or last burst (1 read) |
| ddr_mode | output | 1 | 1 when the burst runs at double data rate |
| dq_oe | output | 1 | Data-pin output enable, one cycle behind the read state |

## Verification
The bench builds the block with `ADDR_W` = 10 and the default single output-enable stage. The address is wide enough that the upper field (bits 9:2) shows clearly whether it is held, yet small enough to write every expected value by hand. With that width, each start value in both orders is in reach. So are wrap-around after the fourth beat, back-to-back loads that keep `dq_oe` high, and the `dq_oe` fall edge one cycle after an idle. Directed steps then cover the reset state and a reset in the middle of a read burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // two low address bits form the four-beat window
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_CONT = 2'd1,
        CMD_LOAD = 2'd2
    } burst_cmd_e;

    typedef struct packed {
        logic                  live;
        logic                  rd;
        logic                  ddr;
        logic                  lin;
        logic [BURST_W-1:0]    beat;
    } burst_ctl_t;

    // low address bits for a given start value and beat number
    function automatic logic [BURST_W-1:0] beat_offset(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] beat,
        input logic               lin
    );
        logic [BURST_W-1:0] r;
        if (lin) r = start + beat;
        else     r = start ^ beat;
        return r;
    endfunction

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
    import burst_seq_pkg::*;
(
    input  logic       load_n,
    input  logic       rw_sel,
    output burst_cmd_e cmd
);
    always_comb begin
        if (!load_n)     cmd = CMD_LOAD;
        else if (rw_sel) cmd = CMD_CONT;
        else             cmd = CMD_IDLE;
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  burst_cmd_e        cmd,
    input  logic              rw_sel,
    input  logic              rate_sel,
    input  logic              linear_order,
    input  logic [ADDR_W-1:0] ext_addr,
    output burst_ctl_t        ctl,
    output logic [ADDR_W-1:0] arr_addr
);
    localparam int HI_W = ADDR_W - BURST_W;

    logic [ADDR_W-1:0] base_q;
    burst_ctl_t        ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            ctl_q  <= '0;
        end else begin
            case (cmd)
                CMD_LOAD: begin
                    base_q     <= ext_addr;
                    ctl_q.live <= 1'b1;
                    ctl_q.rd   <= rw_sel;
                    ctl_q.ddr  <= ~rate_sel;
                    ctl_q.lin  <= linear_order;
                    ctl_q.beat <= '0;
                end
                CMD_CONT: begin
                    if (ctl_q.live) ctl_q.beat <= ctl_q.beat + 1'b1;
                end
                default: begin
                    ctl_q.live <= 1'b0;
                end
            endcase
        end
    end

    assign ctl      = ctl_q;
    assign arr_addr = {base_q[ADDR_W-1:BURST_W],
                       beat_offset(base_q[BURST_W-1:0], ctl_q.beat, ctl_q.lin)};

    assert_load_addr_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LOAD) |=> (arr_addr == $past(ext_addr)));

    assert_upper_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_CONT) |=> (arr_addr[ADDR_W-1:BURST_W] == $past(arr_addr[ADDR_W-1:BURST_W])));

    assert_rate_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_LOAD) |=> ($stable(ctl_q.ddr) && $stable(ctl_q.rd)));

    assert_idle_cont_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_CONT && !ctl_q.live) |=> $stable(arr_addr));

    initial assert (HI_W >= 1);
endmodule

// File: rtl/burst_oe_pipe.sv
module burst_oe_pipe #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_live,
    output logic oe
);
    logic [STAGES:0] chain;
    assign chain[0] = rd_live;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g+1] <= 1'b0;
                else     chain[g+1] <= chain[g];
            end
        end
    endgenerate

    assign oe = chain[STAGES];
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int OE_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_n,
    input  logic              rw_sel,
    input  logic              rate_sel,
    input  logic              linear_order,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              is_read,
    output logic              ddr_mode,
    output logic              dq_oe
);
    burst_cmd_e cmd;
    burst_ctl_t ctl;
    logic       rd_live;

    burst_cmd_decode u_dec (
        .load_n (load_n),
        .rw_sel (rw_sel),
        .cmd    (cmd)
    );

    burst_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk          (clk),
        .rst          (rst),
        .cmd          (cmd),
        .rw_sel       (rw_sel),
        .rate_sel     (rate_sel),
        .linear_order (linear_order),
        .ext_addr     (ext_addr),
        .ctl          (ctl),
        .arr_addr     (arr_addr)
    );

    assign rd_live = ctl.live & ctl.rd;

    burst_oe_pipe #(.STAGES(OE_STAGES)) u_oe (
        .clk     (clk),
        .rst     (rst),
        .rd_live (rd_live),
        .oe      (dq_oe)
    );

    assign is_read  = ctl.rd;
    assign ddr_mode = ctl.ddr;

    assert_read_load_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LOAD && rw_sel) |=> is_read);

    assert_idle_oe_off_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_IDLE) |=> ##1 !dq_oe);

    assert_write_no_oe_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LOAD && !rw_sel) |=> ##1 !dq_oe);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!dq_oe && !is_read && !ddr_mode && arr_addr == '0));
endmodule

// File: tb/burst_seq_ctrl_tb_top.sv
module burst_seq_ctrl_tb_top;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic          load_n, rw_sel, rate_sel, linear_order;
    logic [AW-1:0] ext_addr;
    logic [AW-1:0] arr_addr;
    logic          is_read, ddr_mode, dq_oe;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    burst_seq_ctrl #(.ADDR_W(AW), .OE_STAGES(1)) dut_i (
        .clk(clk), .rst(rst), .load_n(load_n), .rw_sel(rw_sel),
        .rate_sel(rate_sel), .linear_order(linear_order), .ext_addr(ext_addr),
        .arr_addr(arr_addr), .is_read(is_read), .ddr_mode(ddr_mode), .dq_oe(dq_oe)
    );

    typedef struct packed {
        logic          ld_n;
        logic          rw;
        logic          rate;
        logic          lin;
        logic [AW-1:0] addr;
        logic [AW-1:0] e_addr;
        logic          e_rd;
        logic          e_ddr;
        logic          e_oe;
    } vec_t;

    localparam int NV = 18;
    // {load_n, rw_sel, rate_sel, linear_order, ext_addr, exp addr, exp rd, exp ddr, exp oe}
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b1,1'b1,1'b1,10'h1A5, 10'h1A5,1'b1,1'b0,1'b0}, // R2 read load, R3 SDR
        '{1'b1,1'b1,1'b0,1'b1,10'h000, 10'h1A6,1'b1,1'b0,1'b1}, // R4 linear, R8 oe up, R3 ignored
        '{1'b1,1'b1,1'b1,1'b1,10'h000, 10'h1A7,1'b1,1'b0,1'b1}, // R4
        '{1'b1,1'b1,1'b1,1'b1,10'h000, 10'h1A4,1'b1,1'b0,1'b1}, // R4 mod 4
        '{1'b1,1'b1,1'b1,1'b1,10'h000, 10'h1A5,1'b1,1'b0,1'b1}, // R6 wrap
        '{1'b1,1'b0,1'b1,1'b1,10'h3FF, 10'h1A5,1'b1,1'b0,1'b1}, // R7 idle, oe one more cycle
        '{1'b1,1'b0,1'b1,1'b1,10'h000, 10'h1A5,1'b1,1'b0,1'b0}, // R7 oe low
        '{1'b1,1'b1,1'b0,1'b0,10'h000, 10'h1A5,1'b1,1'b0,1'b0}, // R9 continue while idle
        '{1'b0,1'b0,1'b0,1'b0,10'h0F2, 10'h0F2,1'b0,1'b1,1'b0}, // R2 write load, R3 DDR
        '{1'b1,1'b1,1'b1,1'b1,10'h000, 10'h0F3,1'b0,1'b1,1'b0}, // R5 interleave, R10 lin ignored
        '{1'b1,1'b1,1'b1,1'b1,10'h000, 10'h0F0,1'b0,1'b1,1'b0}, // R5 R10
        '{1'b1,1'b1,1'b1,1'b1,10'h000, 10'h0F1,1'b0,1'b1,1'b0}, // R5 R8 write keeps oe low
        '{1'b0,1'b1,1'b0,1'b0,10'h301, 10'h301,1'b1,1'b1,1'b0}, // R2 read DDR interleaved
        '{1'b1,1'b1,1'b0,1'b1,10'h000, 10'h300,1'b1,1'b1,1'b1}, // R5 R8
        '{1'b0,1'b1,1'b1,1'b1,10'h3FF, 10'h3FF,1'b1,1'b0,1'b1}, // R8 back-to-back read load
        '{1'b1,1'b1,1'b1,1'b1,10'h000, 10'h3FC,1'b1,1'b0,1'b1}, // R6 upper bits held
        '{1'b1,1'b0,1'b0,1'b1,10'h000, 10'h3FC,1'b1,1'b0,1'b1}, // R7
        '{1'b1,1'b0,1'b1,1'b1,10'h000, 10'h3FC,1'b1,1'b0,1'b0}  // R7
    };

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        load_n = v.ld_n; rw_sel = v.rw; rate_sel = v.rate;
        linear_order = v.lin; ext_addr = v.addr;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        rst = 1'b1;
        load_n = 1'b1; rw_sel = 1'b0; rate_sel = 1'b1; linear_order = 1'b1; ext_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 addr", arr_addr, '0);
        chk("R1 is_read", {9'b0, is_read}, 10'd0);
        chk("R1 ddr_mode", {9'b0, ddr_mode}, 10'd0);
        chk("R1 dq_oe", {9'b0, dq_oe}, 10'd0);
        rst = 1'b0;
        drive(VEC[0]);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            chk("R2 R4 R5 R6 R9 R10 addr", arr_addr, VEC[i].e_addr);
            chk("R2 R3 is_read", {9'b0, is_read}, {9'b0, VEC[i].e_rd});
            chk("R3 ddr_mode", {9'b0, ddr_mode}, {9'b0, VEC[i].e_ddr});
            chk("R7 R8 dq_oe", {9'b0, dq_oe}, {9'b0, VEC[i].e_oe});
            if (i + 1 < NV) drive(VEC[i+1]);
        end
        // R1: reset in the middle of a read burst
        load_n = 1'b0; rw_sel = 1'b1; rate_sel = 1'b0; ext_addr = 10'h2AB;
        @(negedge clk);
        load_n = 1'b1;
        @(negedge clk);
        chk("R8 dq_oe before reset", {9'b0, dq_oe}, 10'd1);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-burst addr", arr_addr, '0);
        chk("R1 mid-burst dq_oe", {9'b0, dq_oe}, 10'd0);
        chk("R1 mid-burst ddr", {9'b0, ddr_mode}, 10'd0);
        rst = 1'b0;
        // R9: continue right after reset is ignored
        @(negedge clk);
        @(negedge clk);
        chk("R9 addr after reset", arr_addr, '0);
        chk("R9 dq_oe after reset", {9'b0, dq_oe}, 10'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule